// File: doc/BRIEF.md
# Dual Clock-Synthesizer Serial Loader

This block programs two frequency synthesizers, one per pair of converter channels, from a single packed 28-bit configuration word. On a load command it captures the word and starts two transfers at the same time. Each goes out on a write-only three-wire port made of a serial clock, a data line and a load strobe. Each synthesizer gets a 12-bit packet: its 3-bit N divider code, then its 9-bit M multiplier, sent most significant bit first. The synthesizer output is M/N MHz. The N codes 0 to 7 select divide values of 1, 1.5, 2, 3, 4, 6, 8 and 12.

The four clock-select bits of the word are not shifted. They are captured when a transfer starts and held on static outputs that steer the channel clock multiplexers between the internal and the external source. The block also drives one master-reset line per synthesizer. A load command that arrives during a transfer is held and starts as soon as the current transfer completes. A `done_o` pulse marks the end of each transfer. The ports are never read back.

Top module: `clksyn_loader`

## Requirements
- R1: While `rst_n` is low, the serial clocks, data lines, load strobes, `busy_o`, `done_o` and `clk_sel_o` are all 0, and both `synth_rst_o` lines are 1.
- R2: Both `synth_rst_o` lines read 0 from the first clock edge at which `rst_n` is sampled high.
- R3: Port 0 shifts exactly 12 bits, MSB first: `cfg_i[11:9]` (N code), then `cfg_i[8:0]` (M).
- R4: Port 1 shifts exactly 12 bits, MSB first: `cfg_i[23:21]` (N code), then `cfg_i[20:12]` (M).
- R5: `clk_sel_o[i]` equals `cfg_i[24+i]` of the accepted command (index 0 is channel A, index 3 is channel D; 1 selects external). It updates only on the edge at which a transfer starts.
- R6: The serial clock has a period of `SCLK_DIV` system cycles. Each period is low for its first half. Data changes only while the serial clock is low.
- R7: After the last bit, the load strobe is high for exactly `SCLK_DIV` cycles, and the serial clock stays low during that time.
- R8: `done_o` is a one-cycle pulse that appears `13*SCLK_DIV` cycles after the edge that accepts the command.
- R9: A load command during a transfer is held. The transfer it requests starts on the edge after `done_o`. Of several held commands, only the latest is kept.
- R10: `busy_o` is high from the accepting edge through the `done_o` cycle, and low otherwise.
- R11: The two ports run in lockstep, and their load strobes are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load command, one cycle |
| cfg_i | input | 28 | Packed configuration word |
| ser_clk_o | output | 2 | Serial clock per synthesizer port |
| ser_dat_o | output | 2 | Serial data per port |
| ser_ld_o | output | 2 | Load strobe per port |
| synth_rst_o | output | 2 | Master reset per synthesizer |
| clk_sel_o | output | 4 | Clock multiplexer selects, channels A..D |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished, one-cycle pulse |

## Verification
A bit counter that is off by one shows up as a packet longer or shorter than 12 bits, or shifted by one bit. It also moves the `done_o` pulse by a whole serial period, so the bench sees it at the end of the first transfer. A lost held command or a stale pending register shows up as a missing or extra packet. It also appears on `clk_sel_o` on the edge after `done_o`. A wrong phase counter appears within one serial period, as a bad clock spacing or as data moving while the clock is high.

// File: rtl/clksyn_pkg.sv
// Shared sizes and types for the dual synthesizer loader.
// Assumes a 28-bit packed word: two 12-bit packets, then 4 select bits.
package clksyn_pkg;
    localparam int PKT_W  = 12;
    localparam int NPORT  = 2;
    localparam int NSEL   = 4;
    localparam int CFG_W  = NPORT * PKT_W + NSEL;
    localparam int SEL_LSB = NPORT * PKT_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/clksyn_phase.sv
// Serial-period phase counter. It runs while run_i is high and rests at 0
// otherwise. tick_o marks the last system cycle of a serial period, and
// hi_o marks its second half. Assumes DIV is even and at least 2.
module clksyn_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o,
    output logic hi_o
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

    logic [PH_W-1:0] ph_q;

    // Count through one serial period, wrap at the end, hold at 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)  ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
    end

    assign tick_o = run_i && (ph_q == PH_LAST);
    assign hi_o   = run_i && (ph_q >= PH_HALF);

    p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (hi_o == 1'b0));
endmodule

// File: rtl/clksyn_shift.sv
// One port's packet shifter. It loads a packet on load_i and moves it left
// on shift_i, filling with zeros. The MSB drives the data line.
// Assumes shift_i falls on the last cycle of a serial period.
module clksyn_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         shift_i,
    input  logic         sclk_i,
    output logic         dout_o
);
    logic [W-1:0] sreg_q;

    // Capture a new packet, or advance by one bit at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)       sreg_q <= '0;
        else if (load_i)  sreg_q <= din_i;
        else if (shift_i) sreg_q <= {sreg_q[W-2:0], 1'b0};
    end

    assign dout_o = sreg_q[W-1];

    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_i && $past(sclk_i)) |-> $stable(dout_o));
endmodule

// File: rtl/clksyn_ctrl.sv
// Transfer sequencer: idle, shift 12 bits, strobe, done. It holds one
// pending command (the latest) that arrives while a transfer runs.
// Assumes tick_i comes from a phase counter enabled by run_o.
module clksyn_ctrl
    import clksyn_pkg::*;
#(
    parameter int PW = PKT_W,
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] cfg_i,
    input  logic          tick_i,
    output logic          start_o,
    output logic [CW-1:0] start_cfg_o,
    output logic          shift_o,
    output logic          run_o,
    output logic          sclk_gate_o,
    output logic          strobe_o,
    output logic          done_o,
    output logic          busy_o
);
    localparam int BCW = $clog2(PW);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(PW - 1);

    xfer_state_t   state_q;
    logic [BCW-1:0] bit_q;
    logic          pend_q;
    logic [CW-1:0] pend_cfg_q;
    logic          can_start;

    assign can_start   = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign start_o     = can_start && (load_i || pend_q);
    assign start_cfg_o = load_i ? cfg_i : pend_cfg_q;
    assign shift_o     = (state_q == ST_SHIFT) && tick_i;
    assign run_o       = (state_q == ST_SHIFT) || (state_q == ST_STROBE);
    assign sclk_gate_o = (state_q == ST_SHIFT);
    assign strobe_o    = (state_q == ST_STROBE);
    assign done_o      = (state_q == ST_DONE);
    assign busy_o      = (state_q != ST_IDLE);

    // Advance the transfer state on serial-period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else begin
            case (state_q)
                ST_IDLE, ST_DONE: state_q <= start_o ? ST_SHIFT : ST_IDLE;
                ST_SHIFT:  if (tick_i && bit_q == BIT_LAST) state_q <= ST_STROBE;
                ST_STROBE: if (tick_i) state_q <= ST_DONE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Count the bits sent in the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || start_o) bit_q <= '0;
        else if (shift_o)      bit_q <= bit_q + 1'b1;
    end

    // Keep the latest command that arrives while a transfer cannot start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_cfg_q <= '0;
        end else if (load_i && !can_start) begin
            pend_q     <= 1'b1;
            pend_cfg_q <= cfg_i;
        end else if (start_o) begin
            pend_q     <= 1'b0;
        end
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_held_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pend_q) |=> (state_q == ST_SHIFT));
    p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> $past(state_q == ST_SHIFT));
endmodule

// File: rtl/clksyn_loader.sv
// Dual synthesizer loader top. On a command it sends two 12-bit packets
// (N code, then M, MSB first) on two write-only serial ports at once,
// captures the clock-select bits onto static outputs and holds the
// synthesizer master resets during reset. Assumes SCLK_DIV is even, >= 2.
module clksyn_loader
    import clksyn_pkg::*;
#(
    parameter int SCLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [NPORT-1:0] ser_clk_o,
    output logic [NPORT-1:0] ser_dat_o,
    output logic [NPORT-1:0] ser_ld_o,
    output logic [NPORT-1:0] synth_rst_o,
    output logic [NSEL-1:0]  clk_sel_o,
    output logic             busy_o,
    output logic             done_o
);
    logic             start_w;
    logic [CFG_W-1:0] start_cfg_w;
    logic             shift_w, run_w, gate_w, strobe_w, tick_w, hi_w;
    logic [NSEL-1:0]  sel_q;

    clksyn_ctrl #(.PW(PKT_W), .CW(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .cfg_i(cfg_i),
        .tick_i(tick_w), .start_o(start_w), .start_cfg_o(start_cfg_w),
        .shift_o(shift_w), .run_o(run_w), .sclk_gate_o(gate_w),
        .strobe_o(strobe_w), .done_o(done_o), .busy_o(busy_o)
    );

    clksyn_phase #(.DIV(SCLK_DIV)) u_phase (
        .clk(clk), .rst_n(rst_n), .run_i(run_w),
        .tick_o(tick_w), .hi_o(hi_w)
    );

    // Capture the multiplexer selects when a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (start_w) sel_q <= start_cfg_w[SEL_LSB +: NSEL];
    end
    assign clk_sel_o = sel_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic rst_q;

        clksyn_shift #(.W(PKT_W)) u_shift (
            .clk(clk), .rst_n(rst_n), .load_i(start_w),
            .din_i(start_cfg_w[p*PKT_W +: PKT_W]), .shift_i(shift_w),
            .sclk_i(ser_clk_o[p]), .dout_o(ser_dat_o[p])
        );

        // Hold this synthesizer in master reset while the block is reset.
        always_ff @(posedge clk) begin
            if (!rst_n) rst_q <= 1'b1;
            else        rst_q <= 1'b0;
        end

        assign synth_rst_o[p] = rst_q;
        assign ser_clk_o[p]   = gate_w && hi_w;
        assign ser_ld_o[p]    = strobe_w;
    end

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_w |=> $stable(clk_sel_o));
    p_mrst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (synth_rst_o == '0));
    p_lockstep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ld_o[0] == ser_ld_o[NPORT-1]);
    p_strobe_noclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ld_o != '0) |-> (ser_clk_o == '0));
endmodule

// File: tb/sim_clksyn_loader.sv
`timescale 1ns/1ps
module sim_clksyn_loader;
    localparam int DIV = 4;
    localparam int HN  = 64;

    logic        clk = 1'b0, rst_n = 1'b0, load = 1'b0;
    logic [27:0] cfg = '0;
    logic [1:0]  ser_clk, ser_dat, ser_ld, synth_rst;
    logic [3:0]  clk_sel;
    logic        busy, done;

    int checks = 0, fails = 0, cyc = 0;

    clksyn_loader #(.SCLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load), .cfg_i(cfg),
        .ser_clk_o(ser_clk), .ser_dat_o(ser_dat), .ser_ld_o(ser_ld),
        .synth_rst_o(synth_rst), .clk_sel_o(clk_sel),
        .busy_o(busy), .done_o(done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Port monitor: rebuilds packets and counts timing violations.
    logic [1:0]  pclk, pstb, pdat;
    logic [11:0] acc [2];
    int nb [2], gap [2], stbl [2], seen [2], hcnt [2];
    logic [11:0] hist [2][HN];
    int hbits [2][HN];
    int v_dat = 0, v_per = 0, v_stb = 0, v_sync = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pclk = '0; pstb = '0; pdat = '0;
            for (int p = 0; p < 2; p++) begin
                acc[p] = '0; nb[p] = 0; gap[p] = 0; stbl[p] = 0; seen[p] = 0; hcnt[p] = 0;
            end
        end else begin
            if (ser_ld[0] != ser_ld[1]) v_sync++;
            for (int p = 0; p < 2; p++) begin
                gap[p]++;
                if (ser_clk[p] && !pclk[p]) begin
                    acc[p] = {acc[p][10:0], ser_dat[p]};
                    nb[p]++;
                    if (seen[p] != 0 && gap[p] != DIV) v_per++;
                    seen[p] = 1; gap[p] = 0;
                end
                if (ser_clk[p] && pclk[p] && ser_dat[p] != pdat[p]) v_dat++;
                if (ser_ld[p]) begin
                    stbl[p]++;
                    if (ser_clk[p]) v_stb++;
                end
                if (!ser_ld[p] && pstb[p]) begin
                    if (stbl[p] != DIV) v_stb++;
                    if (hcnt[p] < HN) begin
                        hist[p][hcnt[p]] = acc[p];
                        hbits[p][hcnt[p]] = nb[p];
                    end
                    hcnt[p]++; nb[p] = 0; seen[p] = 0; stbl[p] = 0;
                end
                pclk[p] = ser_clk[p]; pstb[p] = ser_ld[p]; pdat[p] = ser_dat[p];
            end
        end
    end

    function automatic logic [11:0] exp_pkt(input logic [27:0] c, input int p);
        return (p == 0) ? {c[11:9], c[8:0]} : {c[23:21], c[20:12]};
    endfunction

    // Check one recorded packet pair against a command word.
    task automatic chk_packets(input logic [27:0] c, input int idx);
        chk(hbits[0][idx] == 12, "R3 bit count", hbits[0][idx], 12);
        chk(hist[0][idx] == exp_pkt(c, 0), "R3 port0 packet", hist[0][idx], exp_pkt(c, 0));
        chk(hbits[1][idx] == 12, "R4 bit count", hbits[1][idx], 12);
        chk(hist[1][idx] == exp_pkt(c, 1), "R4 port1 packet", hist[1][idx], exp_pkt(c, 1));
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk); n++;
        end
    endtask

    // One full transfer with timing, select and packet checks.
    task automatic xfer(input logic [27:0] c);
        int h0, n;
        h0 = hcnt[0];
        @(negedge clk); load = 1'b1; cfg = c;
        @(negedge clk); load = 1'b0; cfg = $urandom;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        chk(clk_sel == c[27:24], "R5 select capture", clk_sel, c[27:24]);
        wait_done(n);
        chk(n == 13 * DIV, "R8 done latency", n, 13 * DIV);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(busy == 1'b0, "R10 idle after done", busy, 0);
        chk(hcnt[0] == h0 + 1 && hcnt[1] == h0 + 1, "R11 one packet per port",
            hcnt[1], h0 + 1);
        chk_packets(c, h0);
        chk(v_per == 0, "R6 serial clock period", v_per, 0);
        chk(v_dat == 0, "R6 data stable while clock high", v_dat, 0);
        chk(v_stb == 0, "R7 strobe length and quiet clock", v_stb, 0);
        chk(v_sync == 0, "R11 strobes aligned", v_sync, 0);
    endtask

    initial begin
        logic [27:0] ca, cb, cc;
        int h0, n;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ser_clk == 2'b00 && ser_dat == 2'b00 && ser_ld == 2'b00, "R1 serial idle",
            {ser_clk, ser_dat, ser_ld}, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags", {busy, done}, 0);
        chk(clk_sel == 4'h0, "R1 select", clk_sel, 0);
        chk(synth_rst == 2'b11, "R1 master reset", synth_rst, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(synth_rst == 2'b00, "R2 master reset release", synth_rst, 0);

        // Directed corners, then random words.
        xfer(28'h0000000);
        xfer(28'hFFFFFFF);
        xfer(28'h5A00FFF);
        xfer(28'hA7FF000);
        for (int i = 0; i < 8; i++) xfer(28'($urandom));

        // R9: two commands during a transfer; only the latest runs next.
        ca = 28'h3123456; cb = 28'h9ABCDEF; cc = 28'hC0F0F0F;
        h0 = hcnt[0];
        @(negedge clk); load = 1'b1; cfg = ca;
        @(negedge clk); load = 1'b0;
        repeat (10) @(negedge clk);
        load = 1'b1; cfg = cb;
        @(negedge clk); load = 1'b0;
        repeat (5) @(negedge clk);
        load = 1'b1; cfg = cc;
        @(negedge clk); load = 1'b0;
        chk(clk_sel == ca[27:24], "R9 select unchanged while held", clk_sel, ca[27:24]);
        wait_done(n);
        @(negedge clk);
        chk(busy == 1'b1, "R9 held command starts", busy, 1);
        chk(clk_sel == cc[27:24], "R9 latest command kept", clk_sel, cc[27:24]);
        wait_done(n);
        chk(n == 13 * DIV, "R9 held transfer length", n, 13 * DIV);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R9 no further transfer", busy, 0);
        chk(hcnt[0] == h0 + 2, "R9 two packets only", hcnt[0], h0 + 2);
        chk_packets(ca, h0);
        chk_packets(cc, h0 + 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule